// File: doc/BRIEF.md
# Sample Smoothing Filter and Threshold Monitor

This block sits after an analog-to-digital converter's result path and post-processes a stream of tagged conversion results. Each result has a 12-bit value and a 4-bit tag. The top tag bit names the converter unit and the lower three bits name the channel. The block holds a configurable number of smoothing slots. Each one keeps a first-order running average for a single tag, with a power-of-two weight. It also holds a configurable number of threshold monitors. Each monitor watches one tag and compares every raw value it sees against an upper and a lower limit.

Monitor hits and per-unit completion events set sticky interrupt bits. These bits are cleared by a write-one-to-clear pulse and gated by an enable mask. The bits come out in a fixed layout so that a register neighbour can map them straight onto the upper six bits of a 32-bit interrupt word. Configuration arrives as static input ports. Whatever register file drives those ports is outside this block.

Top module: `adc_smooth_mon`

## Requirements
- R1: On each update, a smoothing slot computes avg' = avg - avg/k + sample/k on an internal value that carries 6 fractional bits. The weight code per slot selects k: 0 gives k=2, 1 gives k=4, 2 gives k=8, 3 gives k=16, and codes 4 to 7 give k=64.
- R2: The first matching result after reset or after a slot clear loads that result straight into the average, with no blending.
- R3: A slot updates only for a valid result whose 4-bit tag equals the slot's tag. On that update its one-cycle update strobe goes high in the cycle after the result. Every other result leaves the slot's average unchanged.
- R4: A slot whose tag is 0xF is off. It never updates, even for a result tagged 0xF.
- R5: A slot clear pulse sets that slot's average to zero in the next cycle and re-arms the direct load of R2. A clear takes priority over a result in the same cycle.
- R6: The average output is the internal value with its 6 fractional bits truncated. For example, with k=64, a value of 0 followed by 4095 gives 63.
- R7: A monitor sets its high flag for a matching raw result strictly above its upper limit, and its low flag for one strictly below its lower limit. A result equal to either limit sets nothing.
- R8: A monitor whose tag is 0xF is off and sets no flag.
- R9: Interrupt vector layout for two monitors: bit 0 is monitor 1 low, bit 1 is monitor 0 low, bit 2 is monitor 1 high, bit 3 is monitor 0 high, bit 4 is unit 2 done, and bit 5 is unit 1 done.
- R10: Every valid result sets the unit-1 done bit when its tag bit 3 is 0, and the unit-2 done bit when tag bit 3 is 1.
- R11: Raw interrupt bits are sticky until a one is pulsed on the matching clear bit. If a bit is set and cleared in the same cycle, the set wins.
- R12: The status output is the raw bits ANDed with the enable mask. The interrupt line is the OR of the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Result valid |
| smp_tag | input | 4 | Result tag {unit, channel[2:0]} |
| smp_data | input | 12 | Result value |
| flt_tag | input | 8 | Per-slot tag, slot n at [4n+3:4n] |
| flt_kcode | input | 6 | Per-slot weight code, slot n at [3n+2:3n] |
| flt_clr | input | 2 | Per-slot clear pulse |
| mon_tag | input | 8 | Per-monitor tag |
| mon_hi | input | 24 | Per-monitor upper limit |
| mon_lo | input | 24 | Per-monitor lower limit |
| irq_en | input | 6 | Interrupt enable mask |
| irq_clr | input | 6 | Write-one-to-clear pulse |
| flt_avg | output | 24 | Per-slot average, slot n at [12n+11:12n] |
| flt_upd | output | 2 | Per-slot update strobe |
| irq_raw | output | 6 | Sticky raw interrupt bits |
| irq_st | output | 6 | Enabled interrupt bits |
| irq_line | output | 1 | OR of enabled bits |

## Verification
The bench targets the first result after a clear. A design that blended it against zero would report half the value with k=2 and about 1/64 of it with k=64. It drives k=64 steps small enough that a design without fractional bits would never move. It places results exactly on the limits, where a comparison that is not strict would raise a flag. It also places same-cycle set and clear, where a design that let the clear win would lose an event. Disabled tags are probed with results tagged 0xF, where a plain tag compare would wrongly update or flag. Random runs with mixed tags, weight codes and clears are compared cycle by cycle against a bench model.

// File: rtl/asp_pkg.sv
package asp_pkg;
   localparam int KCODE_W = 3;
   localparam int SHIFT_W = 3;

   // weight code -> right shift amount (k = 2**shift)
   function automatic logic [SHIFT_W-1:0] kcode_shift(input logic [KCODE_W-1:0] code);
      logic [SHIFT_W-1:0] s;
      case (code)
         3'd0:    s = 3'd1;
         3'd1:    s = 3'd2;
         3'd2:    s = 3'd3;
         3'd3:    s = 3'd4;
         default: s = 3'd6;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/asp_flt_slot.sv
module asp_flt_slot
   import asp_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int TAG_W  = 4,
   parameter int FRAC_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [TAG_W-1:0]   cfg_tag,
   input  logic [KCODE_W-1:0] cfg_kcode,
   input  logic               in_vld,
   input  logic [TAG_W-1:0]   in_tag,
   input  logic [DATA_W-1:0]  in_data,
   output logic [DATA_W-1:0]  avg_o,
   output logic               upd_o
);
   localparam int ACC_W = DATA_W + FRAC_W;
   localparam logic [TAG_W-1:0] TAG_OFF = '1;

   logic [ACC_W-1:0]   acc;
   logic [ACC_W-1:0]   ext;
   logic [ACC_W-1:0]   blend;
   logic [SHIFT_W-1:0] sh;
   logic               primed;
   logic               hit;

   always_comb begin
      hit   = in_vld && (cfg_tag != TAG_OFF) && (in_tag == cfg_tag);
      sh    = kcode_shift(cfg_kcode);
      ext   = {in_data, {FRAC_W{1'b0}}};
      blend = acc - (acc >> sh) + (ext >> sh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         primed <= 1'b0;
         upd_o  <= 1'b0;
      end else if (clr) begin
         acc    <= '0;
         primed <= 1'b0;
         upd_o  <= 1'b0;
      end else begin
         upd_o <= hit;
         if (hit) begin
            acc    <= primed ? blend : ext;
            primed <= 1'b1;
         end
      end
   end

   assign avg_o = acc[ACC_W-1:FRAC_W];

   AST_FLT_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !primed && !clr) |=> (avg_o == $past(in_data)));            // R2

   AST_FLT_BLEND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && primed && !clr) |=>
         (($past(avg_o) <= $past(in_data)) ?
            (avg_o >= $past(avg_o) && avg_o <= $past(in_data)) :
            (avg_o <= $past(avg_o) && avg_o >= $past(in_data))));           // R1

   AST_FLT_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tag == TAG_OFF && !clr) |=> $stable(acc));                     // R4

   AST_FLT_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (!in_vld || in_tag != cfg_tag)) |=> $stable(avg_o));        // R3

   AST_FLT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (avg_o == '0 && !upd_o));                                   // R5
endmodule

// File: rtl/asp_mon_slot.sv
module asp_mon_slot #(
   parameter int DATA_W = 12,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  cfg_tag,
   input  logic [DATA_W-1:0] cfg_hi,
   input  logic [DATA_W-1:0] cfg_lo,
   input  logic              in_vld,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_data,
   output logic              over_o,
   output logic              under_o
);
   localparam logic [TAG_W-1:0] TAG_OFF = '1;
   logic match;

   always_comb begin
      match   = in_vld && (cfg_tag != TAG_OFF) && (in_tag == cfg_tag);
      over_o  = match && (in_data > cfg_hi);
      under_o = match && (in_data < cfg_lo);
   end

   AST_MON_EQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !((over_o && in_data == cfg_hi) || (under_o && in_data == cfg_lo)));  // R7

   AST_MON_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tag == TAG_OFF) |-> !(over_o || under_o));                        // R8
endmodule

// File: rtl/asp_irq_bank.sv
module asp_irq_bank #(
   parameter int IRQ_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] set_i,
   input  logic [IRQ_W-1:0] clr_i,
   input  logic [IRQ_W-1:0] en_i,
   output logic [IRQ_W-1:0] raw_o,
   output logic [IRQ_W-1:0] st_o,
   output logic             line_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o <= '0;
      else        raw_o <= (raw_o & ~clr_i) | set_i;
   end

   always_comb begin
      st_o   = raw_o & en_i;
      line_o = |st_o;
   end

   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));           // R11

   AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));            // R11

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o != '0) |=> ((raw_o & $past(raw_o & ~clr_i)) == $past(raw_o & ~clr_i))); // R11

   AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      line_o |-> ((raw_o & en_i) != '0));                                    // R12
endmodule

// File: rtl/adc_smooth_mon.sv
module adc_smooth_mon
   import asp_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int TAG_W    = 4,
   parameter int FRAC_W   = 6,
   parameter int NUM_FLT  = 2,
   parameter int NUM_MON  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        smp_vld,
   input  logic [TAG_W-1:0]            smp_tag,
   input  logic [DATA_W-1:0]           smp_data,
   input  logic [NUM_FLT*TAG_W-1:0]    flt_tag,
   input  logic [NUM_FLT*KCODE_W-1:0]  flt_kcode,
   input  logic [NUM_FLT-1:0]          flt_clr,
   input  logic [NUM_MON*TAG_W-1:0]    mon_tag,
   input  logic [NUM_MON*DATA_W-1:0]   mon_hi,
   input  logic [NUM_MON*DATA_W-1:0]   mon_lo,
   input  logic [2*NUM_MON+1:0]        irq_en,
   input  logic [2*NUM_MON+1:0]        irq_clr,
   output logic [NUM_FLT*DATA_W-1:0]   flt_avg,
   output logic [NUM_FLT-1:0]          flt_upd,
   output logic [2*NUM_MON+1:0]        irq_raw,
   output logic [2*NUM_MON+1:0]        irq_st,
   output logic                        irq_line
);
   localparam int IRQ_W  = 2*NUM_MON + 2;
   localparam int LO_B   = 0;
   localparam int HI_B   = NUM_MON;
   localparam int U2_BIT = 2*NUM_MON;
   localparam int U1_BIT = 2*NUM_MON + 1;

   generate
      if (FRAC_W < 6)   begin : g_chk_frac  $error("FRAC_W must cover the largest shift (6)"); end
      if (TAG_W < 2)    begin : g_chk_tag   $error("TAG_W must hold a unit bit and a channel"); end
      if (NUM_FLT < 1)  begin : g_chk_nflt  $error("NUM_FLT must be at least 1"); end
      if (NUM_MON < 1)  begin : g_chk_nmon  $error("NUM_MON must be at least 1"); end
   endgenerate

   logic [NUM_MON-1:0] mon_over;
   logic [NUM_MON-1:0] mon_under;
   logic [IRQ_W-1:0]   irq_set;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLT; gi++) begin : g_flt
         asp_flt_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .FRAC_W(FRAC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (flt_clr[gi]),
            .cfg_tag   (flt_tag[gi*TAG_W +: TAG_W]),
            .cfg_kcode (flt_kcode[gi*KCODE_W +: KCODE_W]),
            .in_vld    (smp_vld),
            .in_tag    (smp_tag),
            .in_data   (smp_data),
            .avg_o     (flt_avg[gi*DATA_W +: DATA_W]),
            .upd_o     (flt_upd[gi])
         );
      end

      for (gi = 0; gi < NUM_MON; gi++) begin : g_mon
         asp_mon_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_tag (mon_tag[gi*TAG_W +: TAG_W]),
            .cfg_hi  (mon_hi[gi*DATA_W +: DATA_W]),
            .cfg_lo  (mon_lo[gi*DATA_W +: DATA_W]),
            .in_vld  (smp_vld),
            .in_tag  (smp_tag),
            .in_data (smp_data),
            .over_o  (mon_over[gi]),
            .under_o (mon_under[gi])
         );
         // higher monitor index sits at the lower bit
         assign irq_set[LO_B + NUM_MON-1-gi] = mon_under[gi];
         assign irq_set[HI_B + NUM_MON-1-gi] = mon_over[gi];
      end
   endgenerate

   assign irq_set[U2_BIT] = smp_vld &&  smp_tag[TAG_W-1];
   assign irq_set[U1_BIT] = smp_vld && !smp_tag[TAG_W-1];

   asp_irq_bank #(.IRQ_W(IRQ_W)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_set),
      .clr_i  (irq_clr),
      .en_i   (irq_en),
      .raw_o  (irq_raw),
      .st_o   (irq_st),
      .line_o (irq_line)
   );

   AST_DONE_UNIT1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !smp_tag[TAG_W-1]) |=> irq_raw[U1_BIT]);                    // R10
   AST_DONE_UNIT2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && smp_tag[TAG_W-1]) |=> irq_raw[U2_BIT]);                     // R10
   AST_MON0_HIGH_POS: assert property (@(posedge clk) disable iff (!rst_n)
      mon_over[0] |=> irq_raw[HI_B + NUM_MON-1]);                             // R9
   AST_MON0_LOW_POS: assert property (@(posedge clk) disable iff (!rst_n)
      mon_under[0] |=> irq_raw[LO_B + NUM_MON-1]);                            // R9
endmodule

// File: tb/tb_adc_smooth_mon.sv
module tb_adc_smooth_mon;
   localparam int DW = 12;
   localparam int TW = 4;
   localparam int NF = 2;
   localparam int NM = 2;
   localparam int IW = 2*NM + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld;
   logic [TW-1:0] smp_tag;
   logic [DW-1:0] smp_data;
   logic [NF*TW-1:0] flt_tag;
   logic [NF*3-1:0] flt_kcode;
   logic [NF-1:0] flt_clr;
   logic [NM*TW-1:0] mon_tag;
   logic [NM*DW-1:0] mon_hi, mon_lo;
   logic [IW-1:0] irq_en, irq_clr;
   logic [NF*DW-1:0] flt_avg;
   logic [NF-1:0] flt_upd;
   logic [IW-1:0] irq_raw, irq_st;
   logic irq_line;

   always #2.5 clk = ~clk;

   adc_smooth_mon dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_tag(smp_tag), .smp_data(smp_data),
      .flt_tag(flt_tag), .flt_kcode(flt_kcode), .flt_clr(flt_clr), .mon_tag(mon_tag),
      .mon_hi(mon_hi), .mon_lo(mon_lo), .irq_en(irq_en), .irq_clr(irq_clr),
      .flt_avg(flt_avg), .flt_upd(flt_upd), .irq_raw(irq_raw), .irq_st(irq_st), .irq_line(irq_line)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [17:0] m_acc [NF];
   bit          m_prim[NF];
   logic [NF-1:0] m_upd;
   logic [IW-1:0] m_raw;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int kval(input logic [2:0] c);
      case (c)
         3'd0: return 2;
         3'd1: return 4;
         3'd2: return 8;
         3'd3: return 16;
         default: return 64;
      endcase
   endfunction

   function automatic logic [17:0] blend(input logic [17:0] a, input logic [DW-1:0] d, input logic [2:0] c);
      int k = kval(c);
      int e = int'(d) * 64;
      return 18'(int'(a) - int'(a) / k + e / k);
   endfunction

   // bench model, applied with the inputs present at a rising edge
   task automatic model_step();
      logic [IW-1:0] set = '0;
      for (int f = 0; f < NF; f++) begin
         logic [TW-1:0] t = flt_tag[f*TW +: TW];
         bit hit = smp_vld && t != 4'hF && smp_tag == t;
         if (flt_clr[f]) begin
            m_acc[f] = '0; m_prim[f] = 0; m_upd[f] = 1'b0;
         end else begin
            m_upd[f] = hit;
            if (hit) begin
               m_acc[f] = m_prim[f] ? blend(m_acc[f], smp_data, flt_kcode[f*3 +: 3]) : {smp_data, 6'd0};
               m_prim[f] = 1;
            end
         end
      end
      for (int m = 0; m < NM; m++) begin
         logic [TW-1:0] t = mon_tag[m*TW +: TW];
         bit hit = smp_vld && t != 4'hF && smp_tag == t;
         if (hit && smp_data > mon_hi[m*DW +: DW]) set[NM + NM-1-m] = 1'b1;
         if (hit && smp_data < mon_lo[m*DW +: DW]) set[NM-1-m] = 1'b1;
      end
      if (smp_vld) begin
         if (smp_tag[TW-1]) set[2*NM] = 1'b1;
         else               set[2*NM+1] = 1'b1;
      end
      m_raw = (m_raw & ~irq_clr) | set;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      for (int f = 0; f < NF; f++) begin
         chk("R1 R3 average", 32'(flt_avg[f*DW +: DW]), 32'(m_acc[f][17:6]));
         chk("R3 update strobe", 32'(flt_upd[f]), 32'(m_upd[f]));
      end
      chk("R11 raw bits", 32'(irq_raw), 32'(m_raw));
      chk("R12 status", 32'(irq_st), 32'(m_raw & irq_en));
      chk("R12 line", 32'(irq_line), 32'(|(m_raw & irq_en)));
      smp_vld = 0; flt_clr = '0; irq_clr = '0;
   endtask

   task automatic send(input logic [TW-1:0] t, input logic [DW-1:0] d);
      smp_vld = 1; smp_tag = t; smp_data = d;
      cyc();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      smp_vld = 0; smp_tag = '0; smp_data = '0;
      flt_tag = '1; flt_kcode = '0; flt_clr = '0;
      mon_tag = '1; mon_hi = '0; mon_lo = '0;
      irq_en = '0; irq_clr = '0;
      for (int f = 0; f < NF; f++) begin m_acc[f] = '0; m_prim[f] = 0; end
      m_upd = '0; m_raw = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("reset average", 32'(flt_avg), 0);
      chk("reset raw", 32'(irq_raw), 0);
      chk("reset line", 32'(irq_line), 0);

      // slot 0: tag 3, k=2; slot 1: tag 9, k=64
      flt_tag = {4'h9, 4'h3}; flt_kcode = {3'd4, 3'd0};
      send(4'h3, 12'd1000);
      chk("R2 first load", 32'(flt_avg[11:0]), 1000);
      send(4'h3, 12'd0);
      chk("R1 k=2 blend", 32'(flt_avg[11:0]), 500);
      send(4'h3, 12'd1);
      chk("R1 R6 k=2 truncated", 32'(flt_avg[11:0]), 250);
      send(4'h5, 12'd4000);
      chk("R3 other tag ignored", 32'(flt_avg[11:0]), 250);
      send(4'h9, 12'd0);
      send(4'h9, 12'd4095);
      chk("R6 k=64 fraction", 32'(flt_avg[23:12]), 63);
      flt_tag[3:0] = 4'hF;
      send(4'hF, 12'd3000);
      chk("R4 off slot holds", 32'(flt_avg[11:0]), 250);
      chk("R4 off slot no strobe", 32'(flt_upd[0]), 0);
      flt_tag[3:0] = 4'h3;
      flt_clr = 2'b01; smp_vld = 1; smp_tag = 4'h3; smp_data = 12'd900;
      cyc();
      chk("R5 clear wins", 32'(flt_avg[11:0]), 0);
      send(4'h3, 12'd800);
      chk("R5 R2 reload after clear", 32'(flt_avg[11:0]), 800);

      // monitors: 0 on tag 2 (100/50), 1 on tag 10 (200/150)
      irq_clr = '1; cyc();
      mon_tag = {4'hA, 4'h2}; mon_hi = {12'd200, 12'd100}; mon_lo = {12'd150, 12'd50};
      send(4'h2, 12'd100);
      chk("R7 equal high quiet, R10 unit1", 32'(irq_raw), 32'b100000);
      send(4'h2, 12'd50);
      chk("R7 equal low quiet", 32'(irq_raw), 32'b100000);
      send(4'h2, 12'd101);
      chk("R9 mon0 high bit3", 32'(irq_raw), 32'b101000);
      send(4'h2, 12'd49);
      chk("R9 mon0 low bit1", 32'(irq_raw), 32'b101010);
      send(4'hA, 12'd149);
      chk("R9 R10 mon1 low bit0 unit2 bit4", 32'(irq_raw), 32'b111011);
      send(4'hA, 12'd201);
      chk("R9 mon1 high bit2", 32'(irq_raw), 32'b111111);
      irq_clr = '1; cyc();
      chk("R11 clear", 32'(irq_raw), 0);
      mon_tag[3:0] = 4'hF;
      send(4'hF, 12'd4095);
      chk("R8 off monitor", 32'(irq_raw), 32'b010000);
      mon_tag[3:0] = 4'h2;
      irq_clr = '1; smp_vld = 1; smp_tag = 4'h2; smp_data = 12'd101;
      cyc();
      chk("R11 set wins", 32'(irq_raw), 32'b101000);
      irq_en = 6'b001000; @(negedge clk);
      chk("R12 status masked", 32'(irq_st), 32'b001000);
      chk("R12 line high", 32'(irq_line), 1);
      irq_en = 6'b000001; @(negedge clk);
      chk("R12 line low", 32'(irq_line), 0);

      // constrained random
      for (int blk = 0; blk < 20; blk++) begin
         logic [TW-1:0] pool[4];
         for (int f = 0; f < NF; f++) begin
            flt_tag[f*TW +: TW] = ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom_range(0, 14));
            flt_kcode[f*3 +: 3] = 3'($urandom_range(0, 7));
         end
         for (int m = 0; m < NM; m++) begin
            logic [DW-1:0] a = 12'($urandom_range(0, 4095));
            logic [DW-1:0] b = 12'($urandom_range(0, 4095));
            mon_tag[m*TW +: TW] = ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom_range(0, 14));
            mon_hi[m*DW +: DW] = (a > b) ? a : b;
            mon_lo[m*DW +: DW] = (a > b) ? b : a;
         end
         irq_en = 6'($urandom);
         pool[0] = flt_tag[3:0]; pool[1] = flt_tag[7:4];
         pool[2] = mon_tag[3:0]; pool[3] = mon_tag[7:4];
         for (int i = 0; i < 150; i++) begin
            int r = $urandom_range(0, 9);
            smp_vld = ($urandom_range(0, 3) != 0);
            smp_tag = (r < 8) ? pool[r % 4] : 4'($urandom);
            r = $urandom_range(0, 5);
            smp_data = (r == 0) ? mon_hi[11:0] : (r == 1) ? mon_lo[11:0] : 12'($urandom);
            flt_clr = ($urandom_range(0, 40) == 0) ? 2'($urandom) : 2'b00;
            irq_clr = ($urandom_range(0, 6) == 0) ? 6'($urandom) : 6'b0;
            cyc();
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule